// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

This block is a 16-bit timer-counter with a byte-wide register port for a CPU. It advances either on an internal tick, one per twelve clocks, or on falling edges of an external count pin. A second pin, the trigger pin, can do one of two things on a falling edge. It can copy the running count into a 16-bit capture/reload register, or it can load the count from that register. The same register supplies the reload value when the counter overflows in reload mode.

Two select inputs come from a serial port's clock selection. When either is high, the block acts as a baud generator. It reloads on every overflow whatever capture/reload mode software chose, it ignores the trigger pin, and it leaves the overflow flag alone. An up/down option uses the trigger pin level as the count direction. Two sticky flags report overflow and trigger events until software clears them.

Top module: `cap_timer16`

## Requirements
- R1: After reset every register reads 0: control (address 0), count low/high (addresses 1/2) and capture low/high (addresses 3/4). Both flag outputs are 0.
- R2: Address 0 is the control register: bit0 run, bit1 source (1 = external pin), bit2 trigger enable, bit3 mode (1 = capture, 0 = reload), bit4 up/down enable, bit6 trigger flag, bit7 overflow flag. Addresses 1..4 hold bytes of the count and capture registers. Reads are combinational. A write takes effect on the next clock.
- R3: While run is 0 the count holds its value, unless it is written or a trigger reload occurs.
- R4: With source 0 the count advances exactly once every 12 clocks while run is 1.
- R5: With source 1 the count advances once per falling edge of the count pin. The pin is sampled every 3 clocks, so each level must last at least 3 clocks. At most one edge is recognised per sample period.
- R6: In capture mode with trigger enable 1 and no baud select, counting up from 0xFFFF gives 0x0000 and sets the overflow flag.
- R7: In reload mode, counting up from 0xFFFF loads the capture/reload value and sets the overflow flag.
- R8: In capture mode with trigger enable 1, a trigger-pin falling edge copies the count into the capture register and sets the trigger flag. The count itself is not changed.
- R9: In reload mode with trigger enable 1 and up/down off, a trigger-pin falling edge loads the count from the capture/reload register and sets the trigger flag.
- R10: With trigger enable 0, trigger-pin edges change neither the count, the capture register nor the trigger flag.
- R11: If either baud select input is 1, the counter reloads on every overflow even when mode is capture. Trigger edges cause no capture, no reload and no trigger flag. The overflow flag is not set.
- R12: With up/down enable 1 in reload mode, a high trigger pin counts up and a low trigger pin counts down. Counting down from the reload value gives 0xFFFF and sets the overflow flag. Trigger edges are ignored in this mode.
- R13: Both flags stay set until software writes 1 to their control bit. Writing 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External trigger / direction input |
| rx_baud | input | 1 | Receive clock select from serial port |
| tx_baud | input | 1 | Transmit clock select from serial port |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky trigger-event flag |

## Verification
The assertions check, on every cycle, five invariants. A stopped counter holds its value. A capture copies exactly the count seen on the trigger event. A disabled trigger or baud selection never raises its flag. A capture-mode rollover lands on zero. The edge detectors never fire on two cycles in a row. The bench scenarios cover what needs a sequence of stimulus and an exact result. These are the twelve-clock tick rate, the external edge count, reload values on overflow and on trigger, the down-count wrap at the reload value, and the write-one-to-clear flag behaviour.

// File: rtl/cap_timer16.sv
module cap_timer16 #(
  parameter int TICK_DIV   = 12,
  parameter int SAMPLE_DIV = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cnt_pin,
  input  logic       trig_pin,
  input  logic       rx_baud,
  input  logic       tx_baud,
  output logic       ovf_flag,
  output logic       ext_flag
);
  localparam int PW = $clog2(TICK_DIV);
  localparam int SW = $clog2(SAMPLE_DIV);
  localparam logic [15:0] TOP = 16'hFFFF;

  logic [PW-1:0] pre;
  logic [SW-1:0] smp;
  logic cnt_m, cnt_s, cnt_ev, trig_m, trig_s, trig_ev;
  logic run, src_ext, trig_en, cap_mode, updown_en;
  logic [15:0] cnt, cap, cnt_nx, cap_nx;
  logic roll;

  wire tick    = (pre == PW'(TICK_DIV - 1));
  wire smp_stb = (smp == SW'(SAMPLE_DIV - 1));
  wire wr_ctrl = wr_en && addr == 3'd0;
  wire wr_clo  = wr_en && addr == 3'd1;
  wire wr_chi  = wr_en && addr == 3'd2;
  wire wr_alo  = wr_en && addr == 3'd3;
  wire wr_ahi  = wr_en && addr == 3'd4;
  wire unused_bit = wdata[5];

  wire baud     = rx_baud | tx_baud;
  wire cap_eff  = cap_mode && !baud;
  wire dn_mode  = updown_en && !cap_mode && !baud;
  wire going_up = !dn_mode || trig_m;
  wire step     = run && (src_ext ? cnt_ev : tick);
  wire trig_act = trig_ev && trig_en && !baud && !dn_mode;
  wire at_top   = going_up ? (cnt == TOP) : (cnt == cap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      smp <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      smp <= smp_stb ? '0 : smp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_m <= 1'b1; cnt_s <= 1'b1; cnt_ev <= 1'b0;
      trig_m <= 1'b1; trig_s <= 1'b1; trig_ev <= 1'b0;
    end else begin
      cnt_m   <= cnt_pin;
      trig_m  <= trig_pin;
      cnt_ev  <= smp_stb && cnt_s && !cnt_m;
      trig_ev <= smp_stb && trig_s && !trig_m;
      if (smp_stb) begin
        cnt_s  <= cnt_m;
        trig_s <= trig_m;
      end
    end
  end

  always_comb begin
    cnt_nx = cnt;
    roll   = 1'b0;
    if (trig_act && !cap_eff) cnt_nx = cap;
    else if (step) begin
      if (at_top) begin
        roll   = 1'b1;
        cnt_nx = going_up ? (cap_eff ? 16'h0000 : cap) : TOP;
      end else begin
        cnt_nx = going_up ? cnt + 16'd1 : cnt - 16'd1;
      end
    end
    if (wr_clo) cnt_nx[7:0]  = wdata;
    if (wr_chi) cnt_nx[15:8] = wdata;
    cap_nx = cap;
    if (trig_act && cap_eff) cap_nx = cnt;
    if (wr_alo) cap_nx[7:0]  = wdata;
    if (wr_ahi) cap_nx[15:8] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run, src_ext, trig_en, cap_mode, updown_en} <= '0;
      ovf_flag <= 1'b0;
      ext_flag <= 1'b0;
      cnt <= '0;
      cap <= '0;
    end else begin
      if (wr_ctrl) {updown_en, cap_mode, trig_en, src_ext, run} <= wdata[4:0];
      ovf_flag <= (roll && !baud) || (ovf_flag && !(wr_ctrl && wdata[7]));
      ext_flag <= trig_act || (ext_flag && !(wr_ctrl && wdata[6]));
      cnt <= cnt_nx;
      cap <= cap_nx;
    end
  end

  always_comb begin
    case (addr)
      3'd0: rdata = {ovf_flag, ext_flag, 1'b0, updown_en, cap_mode, trig_en, src_ext, run};
      3'd1: rdata = cnt[7:0];
      3'd2: rdata = cnt[15:8];
      3'd3: rdata = cap[7:0];
      3'd4: rdata = cap[15:8];
      default: rdata = 8'h00;
    endcase
  end

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !trig_act && !wr_clo && !wr_chi) |=> $stable(cnt));

  assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_act && cap_eff && !wr_alo && !wr_ahi) |=> (cap == $past(cnt)));

  assert_trig_off_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_en && !ext_flag) |=> !ext_flag);

  assert_no_ovf_baud_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ovf_flag) |=> !ovf_flag);

  assert_one_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ev |=> !cnt_ev);

  assert_capture_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cap_eff && !trig_act && cnt == TOP && !wr_clo && !wr_chi)
      |=> (cnt == 16'h0000 && ovf_flag));
endmodule

// File: tb/tb_cap_timer16.sv
`timescale 1ns/100ps
module tb_cap_timer16;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic cnt_pin = 1, trig_pin = 1, rx_baud = 0, tx_baud = 0;
  logic ovf_flag, ext_flag;
  int checks = 0, fails = 0;

  cap_timer16 dut (.*);

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l); rd(lo + 3'd1, h); v = {h, l};
  endtask

  task automatic set16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]); wr(lo + 3'd1, v[15:8]);
  endtask

  task automatic run_ticks(input logic [7:0] ctl, input int k);
    wr(3'd0, ctl | 8'h01);
    repeat (12 * k - 2) @(negedge clk);
    wr(3'd0, ctl & 8'hFE);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_pin = 0;
    repeat (12) @(negedge clk); trig_pin = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); check("R1 reg", d, 0);
    end
    check("R1 flags", {ovf_flag, ext_flag}, 0);
  endtask

  task automatic t_internal();
    logic [15:0] v;
    wr(3'd0, 8'hC0); set16(3'd1, 16'h0100);
    run_ticks(8'h00, 5);
    rd16(3'd1, v); check("R4 five ticks", v, 16'h0105);
    repeat (40) @(negedge clk);
    rd16(3'd1, v); check("R3 stopped hold", v, 16'h0105);
    rd16(3'd1, v); check("R2 count readback", v, 16'h0105);
  endtask

  task automatic t_external();
    logic [15:0] v;
    wr(3'd0, 8'hC0); set16(3'd1, 16'h0000);
    wr(3'd0, 8'h03);
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 0; repeat (6) @(negedge clk);
      cnt_pin = 1; repeat (6) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    wr(3'd0, 8'h02);
    rd16(3'd1, v); check("R5 edge count", v, 5);
  endtask

  task automatic t_wrap_capture();
    logic [15:0] v;
    wr(3'd0, 8'hC0); set16(3'd1, 16'hFFFE);
    run_ticks(8'h0C, 2);
    rd16(3'd1, v); check("R6 wrap to zero", v, 0);
    check("R6 ovf flag", ovf_flag, 1);
  endtask

  task automatic t_reload_ovf();
    logic [15:0] v;
    wr(3'd0, 8'hC0); set16(3'd3, 16'h1234); set16(3'd1, 16'hFFFF);
    run_ticks(8'h00, 1);
    rd16(3'd1, v); check("R7 reload value", v, 16'h1234);
    check("R7 ovf flag", ovf_flag, 1);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    logic [7:0] d;
    wr(3'd0, 8'hC0); wr(3'd0, 8'h0C); set16(3'd1, 16'h5A3C); set16(3'd3, 16'h0000);
    pulse_trig();
    rd16(3'd3, v); check("R8 captured", v, 16'h5A3C);
    rd16(3'd1, v); check("R8 count kept", v, 16'h5A3C);
    check("R8 ext flag", ext_flag, 1);
    wr(3'd0, 8'h0C); repeat (20) @(negedge clk);
    check("R13 flag sticks on write 0", ext_flag, 1);
    wr(3'd0, 8'h4C);
    rd(3'd0, d); check("R13 flag cleared", d[6], 0);
  endtask

  task automatic t_trig_reload();
    logic [15:0] v;
    wr(3'd0, 8'hC0); wr(3'd0, 8'h04); set16(3'd3, 16'h4000); set16(3'd1, 16'h0010);
    pulse_trig();
    rd16(3'd1, v); check("R9 trigger reload", v, 16'h4000);
    check("R9 ext flag", ext_flag, 1);
  endtask

  task automatic t_trig_off();
    logic [15:0] v;
    wr(3'd0, 8'hC0); wr(3'd0, 8'h08); set16(3'd3, 16'h2222); set16(3'd1, 16'h3333);
    pulse_trig();
    rd16(3'd3, v); check("R10 capture untouched", v, 16'h2222);
    rd16(3'd1, v); check("R10 count untouched", v, 16'h3333);
    check("R10 no flag", ext_flag, 0);
  endtask

  task automatic t_baud();
    logic [15:0] v;
    wr(3'd0, 8'hC0); rx_baud = 1;
    set16(3'd3, 16'h00AA); set16(3'd1, 16'hFFFF);
    run_ticks(8'h0C, 1);
    rd16(3'd1, v); check("R11 forced reload", v, 16'h00AA);
    check("R11 no ovf", ovf_flag, 0);
    set16(3'd1, 16'h0777);
    pulse_trig();
    rd16(3'd3, v); check("R11 no capture", v, 16'h00AA);
    check("R11 no ext flag", ext_flag, 0);
    rx_baud = 0; tx_baud = 1;
    set16(3'd1, 16'hFFFF); run_ticks(8'h0C, 1);
    rd16(3'd1, v); check("R11 tx select reload", v, 16'h00AA);
    tx_baud = 0;
  endtask

  task automatic t_updown();
    logic [15:0] v;
    wr(3'd0, 8'hC0); wr(3'd0, 8'h10);
    set16(3'd3, 16'h0100); set16(3'd1, 16'h0102);
    trig_pin = 0; repeat (10) @(negedge clk);
    run_ticks(8'h10, 3);
    rd16(3'd1, v); check("R12 down wrap", v, 16'hFFFF);
    check("R12 ovf flag", ovf_flag, 1);
    trig_pin = 1; repeat (10) @(negedge clk);
    set16(3'd1, 16'h0005);
    run_ticks(8'h10, 2);
    rd16(3'd1, v); check("R12 up count", v, 16'h0007);
    wr(3'd0, 8'h80);
    check("R13 ovf cleared", ovf_flag, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_internal();
    t_external();
    t_wrap_capture();
    t_reload_ovf();
    t_capture();
    t_trig_reload();
    t_trig_off();
    t_baud();
    t_updown();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule